// File: doc/BRIEF.md
# Disk-Interface Task-File Register Decoder

This block is the device end of a parallel disk-drive host bus. The host reaches a set of byte-wide registers through two active-low block selects, a 3-bit address and active-low read and write strobes. The block decodes each access. It stores the registers that the host writes and returns engine-supplied values for the registers that the host reads. It also keeps the drive-select and interrupt-enable state and gates the interrupt line back to the host. An internal command engine sees every stored register on dedicated outputs, receives a one-cycle pulse for each command byte and each data-port access, and raises interrupts and supplies status, error and read data.

The host bus is asynchronous to the device clock. Each strobe passes through a synchronizer, and an access takes effect when the synchronized strobe is seen to rise, so the host must hold select, address and write data until then. Read data is driven combinationally for as long as the read strobe is low. Two devices share the bus. A parameter gives this device its position, and the drive-select bit in the drive/head register decides which of the two answers the host.

Top module: `tfile_decoder`

## Requirements
- R1: The command block is addressed when `cs_cmd_n`=0 and `cs_ctl_n`=1. The control block is addressed when `cs_cmd_n`=1 and `cs_ctl_n`=0. With both selects high or both low, nothing is addressed, `host_rdata_oe` stays 0 and `host_rdata` reads 0. In the command block, addresses 0 to 6 are the data port, error/features, sector count, sector number, cylinder low, cylinder high and drive/head. 8-bit registers read back with a zero upper byte.
- R2: Command-block address 7 returns `eng_status` on reads. A write to it gives one `cmd_valid` pulse of one cycle with the byte on `cmd_code`, and changes no stored register.
- R3: Command-block address 1 returns `eng_error` on reads. A write to it stores the byte in `reg_features`.
- R4: Control-block address 6 returns `eng_status` on reads. A write to it stores bit 2 as soft reset (`srst_o`) and bit 1 as interrupt disable (`nien_o`). Control address 7 reads as {2'b11, ~head[3:0], ~(drv==1), ~(drv==0)}, where head is drive/head bits 3:0. Control addresses 0 to 5 are never driven.
- R5: A write lands on the register outputs three clock edges after the write strobe rises. No register changes while the strobe is held low.
- R6: `intrq_oe` is 1 only when an interrupt is pending, this device is selected and `nien_o` is 0. When `intrq_oe` is 0, `intrq` is 0.
- R7: When a read of command address 7 completes, the pending interrupt is cleared. A read of control address 6 leaves it pending.
- R8: Drive/head bit 4 is the drive select, and this device is selected when it equals parameter `DRIVE_ID`. While the device is not selected, its reads are undriven and have no side effect. Its writes are ignored, except writes to drive/head and to control address 6.
- R9: A pulse on `eng_irq_set` makes `irq_pending` 1. A command write clears it.
- R10: While `srst_o` is 1, the interrupt is cleared, sector count and sector number hold 1, features, cylinders, drive/head and the data register hold 0, and only control-address-6 writes are accepted.
- R11: After `rst_n` is released, sector count and sector number are 1, the other registers, `srst_o`, `nien_o` and `irq_pending` are 0, and `intrq_oe` is 0.
- R12: The data port at command address 0 is `DATA_W` bits wide. A write stores the word in `reg_data` and gives a `data_wr` pulse. A read returns `eng_rdata` and gives a `data_rd` pulse when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| cs_cmd_n | input | 1 | Active-low command-block select |
| cs_ctl_n | input | 1 | Active-low control-block select |
| addr | input | 3 | Register address within the block |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_wdata | input | DATA_W | Write data from the host |
| host_rdata | output | DATA_W | Read data to the host, 0 when undriven |
| host_rdata_oe | output | 1 | Read data output enable |
| intrq | output | 1 | Interrupt level to the host |
| intrq_oe | output | 1 | Interrupt output enable |
| eng_status | input | 8 | Status byte from the command engine |
| eng_error | input | 8 | Error byte from the command engine |
| eng_rdata | input | DATA_W | Data-port read word from the engine |
| eng_irq_set | input | 1 | Engine request to raise an interrupt |
| cmd_valid | output | 1 | One-cycle pulse on a command write |
| cmd_code | output | 8 | Command byte |
| data_wr | output | 1 | One-cycle pulse on a data-port write |
| data_rd | output | 1 | One-cycle pulse on a data-port read |
| reg_data | output | DATA_W | Last data-port word written |
| reg_features | output | 8 | Features register |
| reg_seccnt | output | 8 | Sector count register |
| reg_secnum | output | 8 | Sector number register |
| reg_cyl_lo | output | 8 | Cylinder low register |
| reg_cyl_hi | output | 8 | Cylinder high register |
| reg_dev_head | output | 8 | Drive/head register |
| srst_o | output | 1 | Soft-reset bit |
| nien_o | output | 1 | Interrupt-disable bit |
| irq_pending | output | 1 | Pending interrupt flag |

## Verification
The hardest state to reach is a pending interrupt while another device is selected. From there, a status read must leave the interrupt pending, and a write to the drive/head register must then bring `intrq_oe` back. The stimulus first raises the interrupt through the engine input. It then writes drive/head with the other position. While in that state it tries reads, a sector-count write and a status read, and checks `irq_pending`, the sector count and the enable at the ports. Only after all that does it reselect the device and clear the interrupt with a status read. The three-edge write latency is checked by driving the strobe by hand and sampling the register on each of the following cycles.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_DATA,
    RG_ERRFEAT,
    RG_SECCNT,
    RG_SECNUM,
    RG_CYLLO,
    RG_CYLHI,
    RG_DEVHEAD,
    RG_STATCMD,
    RG_ALTCTL,
    RG_DRVADDR
  } reg_e;

  localparam logic [7:0] SECCNT_DFLT = 8'h01;
  localparam logic [7:0] SECNUM_DFLT = 8'h01;

  function automatic reg_e decode_reg(input logic cmd_n, input logic ctl_n,
                                      input logic [2:0] a);
    reg_e r;
    r = RG_NONE;
    if (!cmd_n && ctl_n) begin
      case (a)
        3'd0: r = RG_DATA;
        3'd1: r = RG_ERRFEAT;
        3'd2: r = RG_SECCNT;
        3'd3: r = RG_SECNUM;
        3'd4: r = RG_CYLLO;
        3'd5: r = RG_CYLHI;
        3'd6: r = RG_DEVHEAD;
        default: r = RG_STATCMD;
      endcase
    end else if (cmd_n && !ctl_n) begin
      if (a == 3'd6)      r = RG_ALTCTL;
      else if (a == 3'd7) r = RG_DRVADDR;
    end
    return r;
  endfunction

  function automatic logic read_ok(input reg_e r, input logic sel);
    return sel && (r != RG_NONE);
  endfunction

  function automatic logic write_ok(input reg_e r, input logic sel);
    if (r == RG_NONE || r == RG_DRVADDR) return 1'b0;
    if (r == RG_DEVHEAD || r == RG_ALTCTL) return 1'b1;
    return sel;
  endfunction

  function automatic logic [7:0] drive_addr_byte(input logic [3:0] head,
                                                 input logic drv);
    return {2'b11, ~head, ~drv, drv};
  endfunction

endpackage

// File: rtl/tfd_strobe_sync.sv
module tfd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic done
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sh;
  logic         prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[N-2:0], strobe_n};
      prev <= sh[N-1];
    end
  end

  assign done = sh[N-1] & ~prev;
endmodule

// File: rtl/tfd_regs.sv
module tfd_regs
  import tfd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  reg_e              wr_reg,
  input  logic              wr_allow,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic              data_wr,
  output logic [DATA_W-1:0] reg_data,
  output logic [7:0]        reg_features,
  output logic [7:0]        reg_seccnt,
  output logic [7:0]        reg_secnum,
  output logic [7:0]        reg_cyl_lo,
  output logic [7:0]        reg_cyl_hi,
  output logic [7:0]        reg_dev_head,
  output logic              srst,
  output logic              nien
);
  logic we;
  assign we = wr_evt && wr_allow && (!srst || wr_reg == RG_ALTCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst <= 1'b0;
      nien <= 1'b0;
    end else if (we && wr_reg == RG_ALTCTL) begin
      srst <= wdata[2];
      nien <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_data     <= '0;
      reg_features <= '0;
      reg_seccnt   <= SECCNT_DFLT;
      reg_secnum   <= SECNUM_DFLT;
      reg_cyl_lo   <= '0;
      reg_cyl_hi   <= '0;
      reg_dev_head <= '0;
      cmd_valid    <= 1'b0;
      cmd_code     <= '0;
      data_wr      <= 1'b0;
    end else if (srst) begin
      reg_data     <= '0;
      reg_features <= '0;
      reg_seccnt   <= SECCNT_DFLT;
      reg_secnum   <= SECNUM_DFLT;
      reg_cyl_lo   <= '0;
      reg_cyl_hi   <= '0;
      reg_dev_head <= '0;
      cmd_valid    <= 1'b0;
      data_wr      <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      data_wr   <= 1'b0;
      if (we) begin
        case (wr_reg)
          RG_DATA: begin
            reg_data <= wdata;
            data_wr  <= 1'b1;
          end
          RG_ERRFEAT: reg_features <= wdata[7:0];
          RG_SECCNT:  reg_seccnt   <= wdata[7:0];
          RG_SECNUM:  reg_secnum   <= wdata[7:0];
          RG_CYLLO:   reg_cyl_lo   <= wdata[7:0];
          RG_CYLHI:   reg_cyl_hi   <= wdata[7:0];
          RG_DEVHEAD: reg_dev_head <= wdata[7:0];
          RG_STATCMD: begin
            cmd_valid <= 1'b1;
            cmd_code  <= wdata[7:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tfd_irq.sv
module tfd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set,
  input  logic clr,
  input  logic sel,
  input  logic nien,
  output logic pending,
  output logic line,
  output logic line_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (soft_rst) pending <= 1'b0;
    else if (set)      pending <= 1'b1;
    else if (clr)      pending <= 1'b0;
  end

  assign line_oe = pending && sel && !nien;
  assign line    = line_oe;
endmodule

// File: rtl/tfile_decoder.sv
module tfile_decoder
  import tfd_pkg::*;
#(
  parameter int   DATA_W   = 16,
  parameter int   SYNC_STG = 2,
  parameter logic DRIVE_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_cmd_n,
  input  logic              cs_ctl_n,
  input  logic [2:0]        addr,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              intrq,
  output logic              intrq_oe,
  input  logic [7:0]        eng_status,
  input  logic [7:0]        eng_error,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              eng_irq_set,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic              data_wr,
  output logic              data_rd,
  output logic [DATA_W-1:0] reg_data,
  output logic [7:0]        reg_features,
  output logic [7:0]        reg_seccnt,
  output logic [7:0]        reg_secnum,
  output logic [7:0]        reg_cyl_lo,
  output logic [7:0]        reg_cyl_hi,
  output logic [7:0]        reg_dev_head,
  output logic              srst_o,
  output logic              nien_o,
  output logic              irq_pending
);
  localparam int PAD_W = DATA_W - 8;

  reg_e acc_reg;
  logic drv_match;
  logic rd_evt;
  logic wr_evt;
  logic stat_clr_evt;
  logic irq_clr;

  assign acc_reg   = decode_reg(cs_cmd_n, cs_ctl_n, addr);
  assign drv_match = (reg_dev_head[4] == DRIVE_ID);

  tfd_strobe_sync #(.STAGES(SYNC_STG)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n), .done(rd_evt)
  );

  tfd_strobe_sync #(.STAGES(SYNC_STG)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n), .done(wr_evt)
  );

  tfd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_evt(wr_evt), .wr_reg(acc_reg),
    .wr_allow(write_ok(acc_reg, drv_match)),
    .wdata(host_wdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .data_wr(data_wr),
    .reg_data(reg_data), .reg_features(reg_features),
    .reg_seccnt(reg_seccnt), .reg_secnum(reg_secnum),
    .reg_cyl_lo(reg_cyl_lo), .reg_cyl_hi(reg_cyl_hi),
    .reg_dev_head(reg_dev_head), .srst(srst_o), .nien(nien_o)
  );

  assign stat_clr_evt = rd_evt && drv_match && (acc_reg == RG_STATCMD);
  assign data_rd      = rd_evt && drv_match && (acc_reg == RG_DATA);
  assign irq_clr      = stat_clr_evt || cmd_valid;

  tfd_irq u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(srst_o),
    .set(eng_irq_set), .clr(irq_clr), .sel(drv_match), .nien(nien_o),
    .pending(irq_pending), .line(intrq), .line_oe(intrq_oe)
  );

  assign host_rdata_oe = !host_rd_n && read_ok(acc_reg, drv_match);

  always_comb begin
    host_rdata = '0;
    if (host_rdata_oe) begin
      case (acc_reg)
        RG_DATA:    host_rdata = eng_rdata;
        RG_ERRFEAT: host_rdata = {{PAD_W{1'b0}}, eng_error};
        RG_SECCNT:  host_rdata = {{PAD_W{1'b0}}, reg_seccnt};
        RG_SECNUM:  host_rdata = {{PAD_W{1'b0}}, reg_secnum};
        RG_CYLLO:   host_rdata = {{PAD_W{1'b0}}, reg_cyl_lo};
        RG_CYLHI:   host_rdata = {{PAD_W{1'b0}}, reg_cyl_hi};
        RG_DEVHEAD: host_rdata = {{PAD_W{1'b0}}, reg_dev_head};
        RG_STATCMD,
        RG_ALTCTL:  host_rdata = {{PAD_W{1'b0}}, eng_status};
        RG_DRVADDR: host_rdata = {{PAD_W{1'b0}},
                                  drive_addr_byte(reg_dev_head[3:0], reg_dev_head[4])};
        default:    host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              intrq,
  input logic              intrq_oe,
  input logic              irq_pending,
  input logic              nien_o,
  input logic              drv_match,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rdata_oe,
  input logic              cmd_valid,
  input logic              stat_clr_evt,
  input logic              eng_irq_set,
  input logic              srst_o,
  input logic [7:0]        reg_seccnt,
  input logic [7:0]        reg_features,
  input logic              wr_evt
);
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata_oe |-> host_rdata == '0);  // R1

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);  // R2

  AST_WRITE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !srst_o) |=> $stable(reg_features));  // R5

  AST_INTRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    intrq_oe |-> (irq_pending && drv_match && !nien_o));  // R6

  AST_INTRQ_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !intrq_oe |-> !intrq);  // R6

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_evt && !eng_irq_set) |=> !irq_pending);  // R7

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !drv_match && !srst_o) |=> $stable(reg_seccnt));  // R8

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_irq_set && !srst_o) |=> irq_pending);  // R9

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_o && $past(srst_o)) |-> (reg_seccnt == 8'h01 && !irq_pending));  // R10
endmodule

bind tfile_decoder tfd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .intrq(intrq), .intrq_oe(intrq_oe),
  .irq_pending(irq_pending), .nien_o(nien_o), .drv_match(drv_match),
  .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
  .cmd_valid(cmd_valid), .stat_clr_evt(stat_clr_evt),
  .eng_irq_set(eng_irq_set), .srst_o(srst_o), .reg_seccnt(reg_seccnt),
  .reg_features(reg_features), .wr_evt(wr_evt)
);

// File: tb/tfile_decoder_tb.sv
module tfile_decoder_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_cmd_n = 1'b1, cs_ctl_n = 1'b1;
  logic [2:0]    addr = '0;
  logic          host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_rdata_oe, intrq, intrq_oe;
  logic [7:0]    eng_status = 8'h50, eng_error = 8'h04;
  logic [DW-1:0] eng_rdata = 16'hBEEF;
  logic          eng_irq_set = 1'b0;
  logic          cmd_valid, data_wr, data_rd;
  logic [7:0]    cmd_code;
  logic [DW-1:0] reg_data;
  logic [7:0]    reg_features, reg_seccnt, reg_secnum, reg_cyl_lo, reg_cyl_hi, reg_dev_head;
  logic          srst_o, nien_o, irq_pending;

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_dwr = 0, n_drd = 0;
  logic [7:0] last_cmd = '0;
  bit done = 0;

  always #10 clk = ~clk;

  tfile_decoder u_dut (.*);

  always @(posedge clk) begin
    if (cmd_valid) begin n_cmd++; last_cmd = cmd_code; end
    if (data_wr) n_dwr++;
    if (data_rd) n_drd++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic cn, input logic tn, input logic [2:0] a,
                           input logic [DW-1:0] d);
    @(negedge clk); cs_cmd_n = cn; cs_ctl_n = tn; addr = a; host_wdata = d;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
  endtask

  task automatic bus_read(input logic cn, input logic tn, input logic [2:0] a,
                          output logic oe, output logic [DW-1:0] d);
    @(negedge clk); cs_cmd_n = cn; cs_ctl_n = tn; addr = a;
    @(negedge clk); host_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    oe = host_rdata_oe; d = host_rdata;
    host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
  endtask

  // {is_wr, cs_cmd_n, cs_ctl_n, addr, wdata, exp_oe, exp_rdata}
  localparam int NV = 24;
  localparam logic [38:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 1'b1, 3'd2, 16'h0005, 1'b0, 16'h0000},  // R1 sector count
    {1'b0, 1'b0, 1'b1, 3'd2, 16'h0000, 1'b1, 16'h0005},
    {1'b1, 1'b0, 1'b1, 3'd3, 16'h0021, 1'b0, 16'h0000},  // R1 sector number
    {1'b0, 1'b0, 1'b1, 3'd3, 16'h0000, 1'b1, 16'h0021},
    {1'b1, 1'b0, 1'b1, 3'd4, 16'h0034, 1'b0, 16'h0000},  // R1 cylinder low
    {1'b0, 1'b0, 1'b1, 3'd4, 16'h0000, 1'b1, 16'h0034},
    {1'b1, 1'b0, 1'b1, 3'd5, 16'h0012, 1'b0, 16'h0000},  // R1 cylinder high
    {1'b0, 1'b0, 1'b1, 3'd5, 16'h0000, 1'b1, 16'h0012},
    {1'b1, 1'b0, 1'b1, 3'd1, 16'h007E, 1'b0, 16'h0000},  // R3 features write
    {1'b0, 1'b0, 1'b1, 3'd1, 16'h0000, 1'b1, 16'h0004},  // R3 error read
    {1'b0, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b1, 16'h0050},  // R2 status read
    {1'b0, 1'b1, 1'b0, 3'd6, 16'h0000, 1'b1, 16'h0050},  // R4 alt status
    {1'b0, 1'b1, 1'b0, 3'd3, 16'h0000, 1'b0, 16'h0000},  // R4 control 3 undriven
    {1'b0, 1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h0000},  // R4 control 0 undriven
    {1'b0, 1'b1, 1'b0, 3'd5, 16'h0000, 1'b0, 16'h0000},  // R4 control 5 undriven
    {1'b1, 1'b0, 1'b1, 3'd6, 16'h0003, 1'b0, 16'h0000},  // R1 drive/head
    {1'b0, 1'b0, 1'b1, 3'd6, 16'h0000, 1'b1, 16'h0003},
    {1'b0, 1'b1, 1'b0, 3'd7, 16'h0000, 1'b1, 16'h00F2},  // R4 drive address
    {1'b0, 1'b1, 1'b1, 3'd7, 16'h0000, 1'b0, 16'h0000},  // R1 no block
    {1'b0, 1'b0, 1'b0, 3'd2, 16'h0000, 1'b0, 16'h0000},  // R1 both selects
    {1'b1, 1'b0, 1'b1, 3'd0, 16'hCAFE, 1'b0, 16'h0000},  // R12 data write
    {1'b0, 1'b0, 1'b1, 3'd0, 16'h0000, 1'b1, 16'hBEEF},  // R12 data read
    {1'b1, 1'b1, 1'b0, 3'd7, 16'h0055, 1'b0, 16'h0000},  // R4 drive address not writable
    {1'b0, 1'b1, 1'b0, 3'd7, 16'h0000, 1'b1, 16'h00F2}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic oe;
    logic [DW-1:0] d;
    int c0, w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 seccnt", reg_seccnt, 8'h01);
    chk("R11 secnum", reg_secnum, 8'h01);
    chk("R11 cyl_lo", reg_cyl_lo, 8'h00);
    chk("R11 dev_head", reg_dev_head, 8'h00);
    chk("R11 srst/nien/pend", {srst_o, nien_o, irq_pending}, 3'b000);
    chk("R11 intrq_oe", intrq_oe, 1'b0);

    // table walk: R1 R2 R3 R4 R12
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) begin
        bus_write(VEC[i][37], VEC[i][36], VEC[i][35:33], VEC[i][32:17]);
      end else begin
        bus_read(VEC[i][37], VEC[i][36], VEC[i][35:33], oe, d);
        chk($sformatf("R1 R4 table %0d oe", i), oe, VEC[i][16]);
        chk($sformatf("R1 R4 table %0d data", i), d, VEC[i][15:0]);
      end
    end
    chk("R3 features stored", reg_features, 8'h7E);
    chk("R12 data stored", reg_data, 16'hCAFE);
    chk("R12 write pulse count", n_dwr, 1);
    chk("R12 read pulse count", n_drd, 1);

    // R5 latency of a write, cylinder low 0x34 -> 0x99
    @(negedge clk); cs_cmd_n = 1'b0; cs_ctl_n = 1'b1; addr = 3'd4; host_wdata = 16'h0099;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 held strobe", reg_cyl_lo, 8'h34);
    host_wr_n = 1'b1;
    @(negedge clk); chk("R5 edge1", reg_cyl_lo, 8'h34);
    @(negedge clk); chk("R5 edge2", reg_cyl_lo, 8'h34);
    @(negedge clk); chk("R5 edge3", reg_cyl_lo, 8'h99);
    repeat (3) @(negedge clk); cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;

    // R2 command write
    c0 = n_cmd;
    bus_write(1'b0, 1'b1, 3'd7, 16'h0020);
    chk("R2 cmd pulse", n_cmd - c0, 1);
    chk("R2 cmd code", last_cmd, 8'h20);
    chk("R2 seccnt untouched", reg_seccnt, 8'h05);

    // R12 second data word
    w0 = n_dwr;
    bus_write(1'b0, 1'b1, 3'd0, 16'h1234);
    chk("R12 data word", reg_data, 16'h1234);
    chk("R12 data pulse", n_dwr - w0, 1);

    // R9 R6 R7 interrupt raise, alt status keeps, status clears
    @(negedge clk); eng_irq_set = 1'b1;
    @(negedge clk); eng_irq_set = 1'b0;
    chk("R9 pending set", irq_pending, 1'b1);
    chk("R6 intrq driven", {intrq_oe, intrq}, 2'b11);
    bus_read(1'b1, 1'b0, 3'd6, oe, d);
    chk("R7 alt status keeps", irq_pending, 1'b1);
    bus_read(1'b0, 1'b1, 3'd7, oe, d);
    chk("R7 status clears", irq_pending, 1'b0);
    chk("R6 intrq released", {intrq_oe, intrq}, 2'b00);

    // R6 nien masks; R9 command clears
    bus_write(1'b1, 1'b0, 3'd6, 16'h0002);
    chk("R4 nien bit", nien_o, 1'b1);
    @(negedge clk); eng_irq_set = 1'b1;
    @(negedge clk); eng_irq_set = 1'b0;
    chk("R6 masked", {irq_pending, intrq_oe, intrq}, 3'b100);
    bus_write(1'b1, 1'b0, 3'd6, 16'h0000);
    chk("R6 unmasked", intrq_oe, 1'b1);
    bus_write(1'b0, 1'b1, 3'd7, 16'h00EC);
    chk("R9 command clears", irq_pending, 1'b0);

    // R8 other drive selected
    @(negedge clk); eng_irq_set = 1'b1;
    @(negedge clk); eng_irq_set = 1'b0;
    bus_write(1'b0, 1'b1, 3'd6, 16'h0010);
    chk("R8 dev_head writable", reg_dev_head, 8'h10);
    chk("R8 intrq off", {irq_pending, intrq_oe}, 2'b10);
    bus_read(1'b0, 1'b1, 3'd2, oe, d);
    chk("R8 read undriven", oe, 1'b0);
    bus_write(1'b0, 1'b1, 3'd2, 16'h0077);
    chk("R8 write ignored", reg_seccnt, 8'h05);
    c0 = n_cmd;
    bus_write(1'b0, 1'b1, 3'd7, 16'h0020);
    chk("R8 command ignored", n_cmd - c0, 0);
    r0 = n_drd;
    bus_read(1'b0, 1'b1, 3'd0, oe, d);
    chk("R8 data read no pulse", n_drd - r0, 0);
    bus_read(1'b0, 1'b1, 3'd7, oe, d);
    chk("R8 status read no clear", irq_pending, 1'b1);
    bus_write(1'b1, 1'b0, 3'd6, 16'h0002);
    chk("R8 devctl writable", nien_o, 1'b1);
    bus_write(1'b1, 1'b0, 3'd6, 16'h0000);
    bus_write(1'b0, 1'b1, 3'd6, 16'h0000);
    chk("R8 reselect drives intrq", intrq_oe, 1'b1);
    bus_read(1'b0, 1'b1, 3'd7, oe, d);
    chk("R7 clear after reselect", irq_pending, 1'b0);

    // R10 soft reset
    @(negedge clk); eng_irq_set = 1'b1;
    @(negedge clk); eng_irq_set = 1'b0;
    bus_write(1'b1, 1'b0, 3'd6, 16'h0004);
    chk("R10 srst bit", srst_o, 1'b1);
    chk("R10 pending cleared", irq_pending, 1'b0);
    chk("R10 seccnt default", reg_seccnt, 8'h01);
    chk("R10 secnum default", reg_secnum, 8'h01);
    chk("R10 cyl/feat cleared", {reg_cyl_lo, reg_cyl_hi, reg_features}, 24'h0);
    bus_write(1'b0, 1'b1, 3'd2, 16'h0033);
    chk("R10 write blocked", reg_seccnt, 8'h01);
    bus_write(1'b1, 1'b0, 3'd6, 16'h0000);
    chk("R10 srst released", srst_o, 1'b0);
    chk("R10 regs stay default", {reg_seccnt, reg_dev_head}, 16'h0100);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule